// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the memory-mastering half of a receive path. Software prepares a circular ring of descriptors in memory, each one pointing at a receive buffer and carrying an ownership flag. When a frame begins on the byte stream, the engine fetches the current descriptor. If the descriptor is handed to the engine, it stores the frame bytes into the buffer as 16-bit little-endian words. It then writes back the stored byte count and a status word that clears the ownership flag, and moves on to the next ring entry. If the descriptor is still held by software, the whole frame is dropped and a missed-frame pulse is raised.

A control block supplies the ring base address, the ring size as a log2 value, and one-cycle start and stop commands. Every start rewinds the engine to the first ring entry. Commands that arrive while a frame is being handled wait until the engine is back between frames.

Top module: `rxr_engine`

## Requirements
- R1: Every start command resets the current entry to index 0. The next frame after a start uses the descriptor at the ring base, wherever the engine had stopped.
- R2: For each frame, the engine first reads descriptor word 1 (byte offset 2). If bit 15 is 0, the engine writes nothing, discards the whole frame, and leaves the current index unchanged.
- R3: Descriptor i sits at the ring base with its low 4 address bits forced to zero, plus 8*i. The index wraps to 0 after entry 2^ring_log2 - 1.
- R4: The buffer address is {word1[7:0], word0}. Capacity is (-word2[11:0]) mod 4096, so a zero field gives zero capacity. Byte k is written to the low byte (even k) or high byte (odd k) of the word at buffer + k - k%2. A final odd byte is written with a zero high byte.
- R5: Bytes past the capacity are dropped. In that case status bits 12 and 14 are set, and any byte already held for an incomplete word is still written.
- R6: Word 3 (offset 6) receives the number of bytes stored, trailing CRC bytes included, in bits 11:0, with bits 15:12 zero.
- R7: Word 1 is written back last, after all data words and word 3. Its layout is: bit 15 = 0, bit 14 = OR of bits 13..10, bit 13 = framing error flag on the last byte, bit 12 = overflow, bit 11 = CRC error flag on the last byte, bit 10 = 0, bits 9 and 8 = 1, bits 7:0 = the buffer's upper address byte.
- R8: `rint` is high for exactly the one cycle after the status write-back is acknowledged. `miss` is high for exactly the one cycle after a word-1 read that returned bit 15 = 0 is acknowledged.
- R9: After reset and after a stop, the engine accepts and discards incoming frames with no memory access and no pulses.
- R10: Start and stop commands that arrive during a frame are held and applied once the engine is back between frames. If both are pending, start wins.
- R11: Once `mem_req` is raised, address, direction and write data stay unchanged until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Start pulse; rewinds the ring index |
| ctl_stop | input | 1 | Stop pulse |
| ring_base | input | 24 | Ring base byte address (low 4 bits ignored) |
| ring_log2 | input | 3 | log2 of the ring entry count |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Framing error, sampled with the last byte |
| rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes on this cycle's edge |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| rint | output | 1 | Receive-complete pulse |
| miss | output | 1 | Missed-frame pulse |

## Verification
A command and a frame can fall in the same cycle in two ways. A start or stop can arrive while a frame is being stored, so the command must wait until after the status write-back. A start and a stop can also be pulsed together while idle. The bench fires start and stop in the middle of frames and then judges the next frame's landing descriptor from its expected memory writes. It also fires both commands in one cycle and checks that the following frame is stored from index 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int ADDR_W = 24;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 12;

    // byte offsets of the descriptor words
    localparam logic [3:0] OFF_BUF_LO = 4'd0;
    localparam logic [3:0] OFF_STATUS = 4'd2;
    localparam logic [3:0] OFF_SIZE   = 4'd4;
    localparam logic [3:0] OFF_MSG    = 4'd6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DROP,
        S_RD_ST,
        S_RD_LO,
        S_RD_CNT,
        S_DATA,
        S_WR_MC,
        S_WR_ST
    } rx_state_e;

    typedef struct packed {
        logic       own;
        logic       any_err;
        logic       fram;
        logic       oflo;
        logic       crc;
        logic       buff;
        logic       stp;
        logic       enp;
        logic [7:0] addr_hi;
    } desc_status_t;

    function automatic logic [CNT_W-1:0] size_to_cap(input logic [CNT_W-1:0] field);
        return CNT_W'(0) - field;
    endfunction

    function automatic desc_status_t close_status(input logic ovf, input logic fram,
                                                  input logic crc, input logic [7:0] hi);
        desc_status_t s;
        s.own     = 1'b0;
        s.fram    = fram;
        s.oflo    = ovf;
        s.crc     = crc;
        s.buff    = 1'b0;
        s.any_err = ovf | fram | crc;
        s.stp     = 1'b1;
        s.enp     = 1'b1;
        s.addr_hi = hi;
        return s;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int MAX_LOG2 = 7,
    parameter int LOG_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reload,
    input  logic                advance,
    input  logic [LOG_W-1:0]    log2_len,
    output logic [MAX_LOG2-1:0] idx
);
    logic [MAX_LOG2-1:0] mask;

    generate
        for (genvar b = 0; b < MAX_LOG2; b++) begin : g_mask
            assign mask[b] = (LOG_W'(b) < log2_len);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || reload)
            idx <= '0;
        else if (advance)
            idx <= (idx + 1'b1) & mask;
    end
endmodule

// File: rtl/rxr_byte_pack.sv
module rxr_byte_pack #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cap_in,
    input  logic             take,
    input  logic [7:0]       din,
    input  logic             last,
    input  logic             wr_done,
    output logic             word_rdy,
    output logic [15:0]      word,
    output logic [CNT_W-1:0] word_off,
    output logic [CNT_W-1:0] stored,
    output logic [CNT_W-1:0] cap,
    output logic             ovf
);
    logic [7:0] lo_q;
    logic       lo_full;
    logic       keep;

    assign keep = (stored < cap);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            lo_q     <= '0;
            lo_full  <= 1'b0;
            word_rdy <= 1'b0;
            word     <= '0;
            word_off <= '0;
            stored   <= '0;
            ovf      <= 1'b0;
            cap      <= rst ? '0 : cap_in;
        end else if (wr_done) begin
            word_rdy <= 1'b0;
            word_off <= word_off + CNT_W'(2);
        end else if (take) begin
            if (keep) begin
                stored <= stored + 1'b1;
                if (lo_full) begin
                    word     <= {din, lo_q};
                    word_rdy <= 1'b1;
                    lo_full  <= 1'b0;
                end else if (last) begin
                    word     <= {8'h00, din};
                    word_rdy <= 1'b1;
                end else begin
                    lo_q    <= din;
                    lo_full <= 1'b1;
                end
            end else begin
                ovf <= 1'b1;
                if (last && lo_full) begin
                    word     <= {8'h00, lo_q};
                    word_rdy <= 1'b1;
                    lo_full  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int MAX_LOG2 = 7,
    parameter int LOG_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LOG_W-1:0]  ring_log2,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    input  logic              rx_crc_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rint,
    output logic              miss
);
    rx_state_e           st;
    logic                running, pend_start, pend_stop, got_last;
    logic                fram_q, crc_q;
    logic [15:0]         buf_lo;
    logic [7:0]          buf_hi;
    logic [MAX_LOG2-1:0] idx;
    logic [ADDR_W-1:0]   desc_addr, buf_addr;
    logic                cmd_start, cmd_stop, take, ptr_reload, ptr_adv;
    logic                pk_load, pk_done, pk_rdy, pk_ovf;
    logic [15:0]         pk_word;
    logic [CNT_W-1:0]    pk_off, pk_stored, pk_cap;
    desc_status_t        st_word;

    assign cmd_start  = ctl_start | pend_start;
    assign cmd_stop   = ctl_stop | pend_stop;
    assign take       = rx_valid & rx_ready;
    assign ptr_reload = (st == S_IDLE) && cmd_start;
    assign ptr_adv    = (st == S_WR_ST) && mem_ack;
    assign pk_load    = (st == S_RD_CNT) && mem_ack;
    assign pk_done    = (st == S_DATA) && pk_rdy && mem_ack;
    assign desc_addr  = {ring_base[ADDR_W-1:4], 4'h0} + ADDR_W'({idx, 3'b000});
    assign buf_addr   = {buf_hi, buf_lo} + ADDR_W'(pk_off);
    assign st_word    = close_status(pk_ovf, fram_q, crc_q, buf_hi);

    rxr_ring_ptr #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_ptr (
        .clk(clk), .rst(rst), .reload(ptr_reload), .advance(ptr_adv),
        .log2_len(ring_log2), .idx(idx)
    );

    rxr_byte_pack #(.CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst(rst), .load(pk_load),
        .cap_in(size_to_cap(mem_rdata[CNT_W-1:0])),
        .take(take && st == S_DATA), .din(rx_data), .last(rx_last),
        .wr_done(pk_done), .word_rdy(pk_rdy), .word(pk_word),
        .word_off(pk_off), .stored(pk_stored), .cap(pk_cap), .ovf(pk_ovf)
    );

    always_comb begin
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        unique case (st)
            S_DROP:   rx_ready = 1'b1;
            S_RD_ST:  begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(OFF_STATUS); end
            S_RD_LO:  begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(OFF_BUF_LO); end
            S_RD_CNT: begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(OFF_SIZE); end
            S_DATA: begin
                rx_ready  = !pk_rdy && !got_last;
                mem_req   = pk_rdy;
                mem_we    = 1'b1;
                mem_addr  = buf_addr;
                mem_wdata = pk_word;
            end
            S_WR_MC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFF_MSG);
                mem_wdata = WORD_W'(pk_stored);
            end
            S_WR_ST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFF_STATUS);
                mem_wdata = st_word;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            running    <= 1'b0;
            pend_start <= 1'b0;
            pend_stop  <= 1'b0;
            got_last   <= 1'b0;
            fram_q     <= 1'b0;
            crc_q      <= 1'b0;
            buf_lo     <= '0;
            buf_hi     <= '0;
            rint       <= 1'b0;
            miss       <= 1'b0;
        end else begin
            rint <= 1'b0;
            miss <= 1'b0;
            if (st != S_IDLE) begin
                if (ctl_start) pend_start <= 1'b1;
                if (ctl_stop)  pend_stop  <= 1'b1;
            end
            unique case (st)
                S_IDLE: begin
                    if (cmd_start || cmd_stop) begin
                        running    <= cmd_start;
                        pend_start <= 1'b0;
                        pend_stop  <= 1'b0;
                    end else if (rx_valid) begin
                        st <= running ? S_RD_ST : S_DROP;
                    end
                end
                S_DROP: if (take && rx_last) st <= S_IDLE;
                S_RD_ST: if (mem_ack) begin
                    if (mem_rdata[15]) begin
                        buf_hi <= mem_rdata[7:0];
                        st     <= S_RD_LO;
                    end else begin
                        miss <= 1'b1;
                        st   <= S_DROP;
                    end
                end
                S_RD_LO: if (mem_ack) begin
                    buf_lo <= mem_rdata;
                    st     <= S_RD_CNT;
                end
                S_RD_CNT: if (mem_ack) begin
                    got_last <= 1'b0;
                    fram_q   <= 1'b0;
                    crc_q    <= 1'b0;
                    st       <= S_DATA;
                end
                S_DATA: begin
                    if (take && rx_last) begin
                        got_last <= 1'b1;
                        fram_q   <= rx_err;
                        crc_q    <= rx_crc_err;
                    end
                    if (got_last && !pk_rdy) st <= S_WR_MC;
                end
                S_WR_MC: if (mem_ack) st <= S_WR_ST;
                S_WR_ST: if (mem_ack) begin
                    rint <= 1'b1;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [23:0]      mem_addr,
    input logic [15:0]      mem_wdata,
    input logic             mem_ack,
    input logic [15:0]      mem_rdata,
    input logic             rint,
    input logic             miss,
    input logic [CNT_W-1:0] stored,
    input logic [CNT_W-1:0] cap
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r8_rint_after_status: assert property (@(posedge clk) disable iff (rst)
        rint |-> $past(mem_req && mem_ack && mem_we && !mem_wdata[15]));

    a_r8_miss_after_read: assert property (@(posedge clk) disable iff (rst)
        miss |-> $past(mem_req && mem_ack && !mem_we && !mem_rdata[15]));

    a_r8_rint_single: assert property (@(posedge clk) disable iff (rst)
        rint |=> !rint);

    a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rint && miss));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        stored <= cap);

    a_r4_stream_bus_apart: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && mem_req));
endmodule

bind rxr_engine rxr_engine_chk #(.CNT_W(rxr_pkg::CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rint(rint), .miss(miss), .stored(pk_stored), .cap(pk_cap)
);

// File: tb/rxr_engine_tb.sv
module rxr_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_start = 0, ctl_stop = 0;
    logic [23:0] ring_base = 24'hA5_0807;
    logic [2:0]  ring_log2 = 3'd2;
    logic        rx_valid = 0, rx_last = 0, rx_err = 0, rx_crc_err = 0;
    logic [7:0]  rx_data = 0;
    logic        rx_ready, mem_req, mem_we, rint, miss;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 0;
    logic [15:0] mem_rdata = 0;

    int total = 0, bad = 0;
    int n_wr = 0, n_rint = 0, n_miss = 0;
    bit started = 0;
    logic exp_rint = 0, exp_miss = 0;
    logic [23:0] held_addr = 0, last_st_addr = 0;
    logic [15:0] mem [0:4095];
    logic [23:0] q_a[$];
    logic [15:0] q_d[$];
    string       q_t[$];

    localparam logic [23:0] DESC0 = 24'hA5_0800;

    always #5 clk = ~clk;

    rxr_engine u_dut (
        .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ring_base(ring_base), .ring_log2(ring_log2), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_crc_err(rx_crc_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rint(rint), .miss(miss)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory slave: one wait cycle per access
    always @(posedge clk) begin
        if (rst) begin
            mem_ack  <= 1'b0;
            exp_rint <= 1'b0;
            exp_miss <= 1'b0;
        end else begin
            exp_rint <= 1'b0;
            exp_miss <= 1'b0;
            if (mem_req && mem_ack) begin
                check(mem_addr == held_addr, "R11 address held", int'(mem_addr), int'(held_addr));
                if (mem_we) begin
                    n_wr++;
                    if (q_a.size() == 0) begin
                        check(0, "R9 unexpected write", int'(mem_addr), 0);
                    end else begin
                        logic [23:0] ea;
                        logic [15:0] ed;
                        string et;
                        ea = q_a.pop_front();
                        ed = q_d.pop_front();
                        et = q_t.pop_front();
                        check(mem_addr == ea, {et, " write address"}, int'(mem_addr), int'(ea));
                        check(mem_wdata == ed, {et, " write data"}, int'(mem_wdata), int'(ed));
                    end
                    mem[mem_addr[12:1]] = mem_wdata;
                    exp_rint <= (mem_addr[12:0] < 13'h1000) && (mem_addr[2:0] == 3'd2);
                end else begin
                    if (mem_addr[2:0] == 3'd2) last_st_addr = mem_addr;
                    exp_miss <= (mem_addr[2:0] == 3'd2) && !mem[mem_addr[12:1]][15];
                end
            end
            if (mem_req && !mem_ack) held_addr <= mem_addr;
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem[mem_addr[12:1]];
        end
    end

    // per-cycle comparison of the pulses (R8)
    always @(negedge clk) begin
        if (started) begin
            check(rint == exp_rint, "R8 rint pulse", int'(rint), int'(exp_rint));
            check(miss == exp_miss, "R8 miss pulse", int'(miss), int'(exp_miss));
            if (rint) n_rint++;
            if (miss) n_miss++;
        end
    end

    function automatic logic [23:0] d_addr(input int i);
        return DESC0 + 24'(i * 8);
    endfunction

    function automatic logic [23:0] b_addr(input int i);
        return 24'h3C_1000 + 24'(i * 256);
    endfunction

    task automatic set_desc(input int i, input int cap);
        logic [23:0] d, b;
        d = d_addr(i);
        b = b_addr(i);
        mem[d[12:1]]     = b[15:0];
        mem[d[12:1] + 1] = {1'b1, 7'b0, b[23:16]};
        mem[d[12:1] + 2] = {4'hF, 12'(-cap)};
        mem[d[12:1] + 3] = 16'h0;
    endtask

    task automatic expect_frame(input int i, input int cap, input int n, input int seed,
                                input bit fram, input bit crc, input string tag);
        int    stored;
        bit    ov;
        logic [7:0] lo, hi;
        stored = (n < cap) ? n : cap;
        ov = (n > cap);
        for (int w = 0; 2 * w < stored; w++) begin
            lo = 8'(seed + 2 * w);
            hi = (2 * w + 1 < stored) ? 8'(seed + 2 * w + 1) : 8'h00;
            q_a.push_back(b_addr(i) + 24'(2 * w));
            q_d.push_back({hi, lo});
            q_t.push_back(tag);
        end
        q_a.push_back(d_addr(i) + 24'd6);
        q_d.push_back(16'(stored));
        q_t.push_back(tag);
        q_a.push_back(d_addr(i) + 24'd2);
        q_d.push_back({1'b0, ov | fram | crc, fram, ov, crc, 1'b0, 1'b1, 1'b1, 8'h3C});
        q_t.push_back(tag);
    endtask

    task automatic send_frame(input int n, input int seed, input bit fram, input bit crc,
                              input int cmd_at, input int cmd_kind);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ctl_start = 0;
            ctl_stop  = 0;
            if (k == cmd_at) begin
                if (cmd_kind == 1) ctl_start = 1;
                else ctl_stop = 1;
            end
            rx_valid   = 1;
            rx_data    = 8'(seed + k);
            rx_last    = (k == n - 1);
            rx_err     = fram && (k == n - 1);
            rx_crc_err = crc && (k == n - 1);
            while (!rx_ready) begin
                @(negedge clk);
                ctl_start = 0;
                ctl_stop  = 0;
            end
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0; rx_err = 0; rx_crc_err = 0;
        ctl_start = 0; ctl_stop = 0;
    endtask

    task automatic settle();
        wait (q_a.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input bit s, input bit p);
        @(negedge clk);
        ctl_start = s;
        ctl_stop  = p;
        @(negedge clk);
        ctl_start = 0;
        ctl_stop  = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0, r0, m0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state (R9)
        check(rx_ready == 0, "R9 reset rx_ready", int'(rx_ready), 0);
        check(mem_req == 0, "R9 reset mem_req", int'(mem_req), 0);
        check(rint == 0, "R9 reset rint", int'(rint), 0);
        check(miss == 0, "R9 reset miss", int'(miss), 0);
        started = 1;
        for (int i = 0; i < 4; i++) set_desc(i, 16);
        set_desc(2, 5);

        // stopped: frame consumed, no access (R9)
        send_frame(5, 8'h10, 0, 0, -1, 0);
        repeat (6) @(negedge clk);
        check(n_wr == 0, "R9 stopped writes", n_wr, 0);
        check(n_rint == 0 && n_miss == 0, "R9 stopped pulses", n_rint + n_miss, 0);

        pulse(1, 0);
        // odd length frame into entry 0 (R3 R4 R6 R7)
        expect_frame(0, 16, 7, 8'h20, 0, 0, "R4");
        send_frame(7, 8'h20, 0, 0, -1, 0);
        settle();
        // CRC error flag (R7)
        expect_frame(1, 16, 10, 8'h40, 0, 1, "R7");
        send_frame(10, 8'h40, 0, 1, -1, 0);
        settle();
        // overflow with odd capacity and framing error (R5 R6)
        expect_frame(2, 5, 9, 8'h60, 1, 0, "R5");
        send_frame(9, 8'h60, 1, 0, -1, 0);
        settle();
        expect_frame(3, 16, 4, 8'h80, 0, 0, "R6");
        send_frame(4, 8'h80, 0, 0, -1, 0);
        settle();
        check(n_rint == 4, "R8 rint count", n_rint, 4);

        // wrap to entry 0, which software has not returned (R2 R3)
        w0 = n_wr;
        send_frame(6, 8'h90, 0, 0, -1, 0);
        repeat (6) @(negedge clk);
        check(last_st_addr == DESC0 + 24'd2, "R3 wrap to entry 0", int'(last_st_addr), int'(DESC0 + 24'd2));
        check(n_miss == 1, "R2 miss count", n_miss, 1);
        check(n_wr == w0, "R2 no write on miss", n_wr - w0, 0);

        // index did not move on the miss (R2)
        set_desc(0, 16);
        expect_frame(0, 16, 3, 8'hA0, 0, 0, "R2");
        send_frame(3, 8'hA0, 0, 0, -1, 0);
        settle();

        // stop then start rewinds to entry 0 (R1)
        pulse(0, 1);
        pulse(1, 0);
        set_desc(0, 16);
        expect_frame(0, 16, 6, 8'hB0, 0, 0, "R1");
        send_frame(6, 8'hB0, 0, 0, -1, 0);
        settle();

        // start during a frame is held until after it (R10)
        set_desc(0, 16);
        set_desc(1, 16);
        expect_frame(1, 16, 8, 8'hC0, 0, 0, "R10");
        send_frame(8, 8'hC0, 0, 0, 3, 1);
        settle();
        expect_frame(0, 16, 5, 8'hD0, 0, 0, "R10");
        send_frame(5, 8'hD0, 0, 0, -1, 0);
        settle();

        // stop during a frame: frame completes, next one dropped (R10 R9)
        set_desc(1, 16);
        expect_frame(1, 16, 6, 8'hE0, 0, 0, "R10");
        send_frame(6, 8'hE0, 0, 0, 2, 2);
        settle();
        w0 = n_wr;
        r0 = n_rint;
        m0 = n_miss;
        set_desc(2, 16);
        send_frame(4, 8'hF0, 0, 0, -1, 0);
        repeat (6) @(negedge clk);
        check(n_wr == w0, "R10 stop held then applied", n_wr - w0, 0);
        check(n_rint == r0 && n_miss == m0, "R9 no pulses when stopped", n_rint - r0 + n_miss - m0, 0);

        // start and stop together: start wins (R10 R1)
        pulse(1, 1);
        set_desc(0, 16);
        expect_frame(0, 16, 2, 8'h11, 0, 0, "R10");
        send_frame(2, 8'h11, 0, 0, -1, 0);
        settle();

        check(q_a.size() == 0, "R7 all writes seen", q_a.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule